// File: doc/BRIEF.md
# Latency Buffer Readout Controller

This block sits between a circular record buffer and a derandomising FIFO. The buffer is a 512-slot dual-port memory that receives one 209-bit record per bunch crossing. Each record holds a bunch number, an error nibble, a valid mask and 192 payload bits. The controller packs the record from its input fields. It drives the buffer write port on every sync pulse from the upstream packer, and a free-running write pointer selects the slot.

A level-1 accept reaches the controller long after the matching crossing was stored. At the accept, the block takes the current write pointer, subtracts a programmable latency preload, and queues that start slot together with a slice count and the trigger slice number. A sequencer then reads a burst of consecutive slots from the buffer. Each read enable is repeated one cycle later as the FIFO write enable, which lines it up with the memory's one-cycle read latency.

Reads pause while the FIFO reports full. Accepts that arrive during a burst wait in a short queue. A software clear pulse empties the readout path. An 8-bit status word reports the sequencer state and the trigger slice being served.

Top module: `lbuf_rdctl`

## Requirements
- R1: The buffer write enable equals `sync_in` in the same cycle. The write data is packed with the bunch number in bits 208:202, zeros in bits 201:198, the valid mask in bits 197:192 and the payload in bits 191:0.
- R2: The write address is 0 after reset and advances by one, modulo 512, in the cycle after each sync. It holds otherwise and is not affected by `sw_clr`.
- R3: An accept sampled at a clock edge while the sequencer is idle, with the queue empty and the FIFO not full, gives a first read two cycles later. The read address of that first read is (write address in the accept cycle − `lat_preload`) modulo 512.
- R4: A slice count value v produces exactly v+1 reads at consecutive addresses, each one greater than the last modulo 512, so 511 is followed by 0.
- R5: `fifo_wr_en` is high exactly when `buf_rd_en` was high in the previous cycle and neither `fifo_full` nor `sw_clr` is high now. The record presented to the FIFO is the buffer content at the address read.
- R6: No read is issued in a cycle where `fifo_full` is high. The burst pauses and then resumes at the same address, and no slot is skipped.
- R7: Up to QDEPTH accepts wait while a burst runs. They are served in arrival order, and each new burst starts in the cycle after the last read of the previous one. An accept that arrives while QDEPTH accepts are waiting and none leaves the queue is dropped and produces no read.
- R8: A `sw_clr` pulse ends the current burst and discards waiting accepts. It blocks reads and FIFO writes in its own cycle and the next one, and an accept in the same cycle is ignored.
- R9: `status[3:0]` reads 0 when idle, 1 when reading, and 2 when a burst is stalled by `fifo_full`. `status[7:4]` holds the trigger slice of the current or most recent burst and is cleared by reset and by `sw_clr`.
- R10: After reset, `status` is 0 and no read or FIFO write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_clr | input | 1 | Software clear pulse for the readout path |
| sync_in | input | 1 | Packer sync; writes one record |
| bcn_in | input | 7 | Bunch number of the record |
| vld_in | input | 6 | Valid mask of the record |
| dat_in | input | 192 | Payload of the record |
| lat_preload | input | 9 | Latency offset subtracted from the write pointer |
| accept_in | input | 1 | Level-1 accept pulse |
| nslice_in | input | 3 | Slices to read minus one |
| tslice_in | input | 4 | Trigger slice number sent with the accept |
| fifo_full | input | 1 | Downstream FIFO full |
| buf_wr_en | output | 1 | Buffer write enable |
| buf_wr_addr | output | 9 | Buffer write address |
| buf_wr_data | output | 209 | Packed record |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_addr | output | 9 | Buffer read address |
| fifo_wr_en | output | 1 | FIFO write enable |
| status | output | 8 | Trigger slice and sequencer state |

## Verification
The bench aims at four corner cases:

- **Start slot below zero.** When the preload exceeds the write pointer, the start slot must wrap near the top of the buffer. A design that subtracted without wrapping, or that broke the burst at slot 511, would read the wrong records.
- **Write pointer wrap.** The pointer is driven once around the full buffer. An off-by-one in the write-enable alignment would then show up as payload mismatches.
- **Full mid-burst.** Holding full in the middle of a burst checks that reads stop and resume at the same slot. A controller that kept counting would lose slices, and one that ignored full would write into a full FIFO.
- **Accept overflow and clear.** A run of accepts overfills the queue and must lose exactly the surplus. A clear mid-burst must leave no stray reads behind.

// File: rtl/lbuf_pkg.sv
`timescale 1ns/1ps
package lbuf_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_READ = 2'd1
    } seq_state_e;

    localparam logic [3:0] STAT_IDLE  = 4'd0;
    localparam logic [3:0] STAT_READ  = 4'd1;
    localparam logic [3:0] STAT_STALL = 4'd2;

endpackage

// File: rtl/lbuf_wrside.sv
`timescale 1ns/1ps
module lbuf_wrside #(
    parameter int AW    = 9,
    parameter int BCN_W = 7,
    parameter int ERR_W = 4,
    parameter int VLD_W = 6,
    parameter int DAT_W = 192,
    localparam int REC_W = BCN_W + ERR_W + VLD_W + DAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic [BCN_W-1:0] bcn_in,
    input  logic [VLD_W-1:0] vld_in,
    input  logic [DAT_W-1:0] dat_in,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [REC_W-1:0] wr_data
);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } wr_st_t;

    wr_st_t wr_d, wr_q;

    always_comb begin
        wr_d = wr_q;
        if (sync_in) begin
            wr_d.ptr = wr_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign wr_en   = sync_in;
    assign wr_addr = wr_q.ptr;
    assign wr_data = {bcn_in, {ERR_W{1'b0}}, vld_in, dat_in};

endmodule

// File: rtl/lbuf_accq.sv
`timescale 1ns/1ps
module lbuf_accq #(
    parameter int EW    = 16,
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    output logic [EW-1:0] pop_data,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } q_st_t;

    q_st_t aq_d, aq_q;
    logic  do_push, do_pop;

    always_comb begin
        aq_d    = aq_q;
        do_pop  = pop && (aq_q.cnt != '0);
        do_push = push && ((aq_q.cnt != CW'(DEPTH)) || do_pop);
        if (do_push) begin
            aq_d.mem[aq_q.wp] = push_data;
            aq_d.wp = (aq_q.wp == PW'(DEPTH - 1)) ? '0 : aq_q.wp + 1'b1;
        end
        if (do_pop) begin
            aq_d.rp = (aq_q.rp == PW'(DEPTH - 1)) ? '0 : aq_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   aq_d.cnt = aq_q.cnt + 1'b1;
            2'b01:   aq_d.cnt = aq_q.cnt - 1'b1;
            default: aq_d.cnt = aq_q.cnt;
        endcase
        if (clr) begin
            aq_d.wp  = '0;
            aq_d.rp  = '0;
            aq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aq_q <= '0;
        end else begin
            aq_q <= aq_d;
        end
    end

    assign pop_data = aq_q.mem[aq_q.rp];
    assign empty    = (aq_q.cnt == '0);

endmodule

// File: rtl/lbuf_rdseq.sv
`timescale 1ns/1ps
module lbuf_rdseq
    import lbuf_pkg::*;
#(
    parameter int AW    = 9,
    parameter int NSL_W = 3,
    parameter int TS_W  = 4,
    localparam int ST_W = TS_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fifo_full,
    input  logic             q_empty,
    input  logic [AW-1:0]    q_start,
    input  logic [NSL_W-1:0] q_nsl,
    input  logic [TS_W-1:0]  q_tsl,
    output logic             q_pop,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    output logic             fifo_we,
    output logic [ST_W-1:0]  status
);

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    addr;
        logic [NSL_W-1:0] left;
        logic [TS_W-1:0]  tsl;
        logic             we;
    } seq_st_t;

    seq_st_t seq_d, seq_q;
    logic    rd;
    logic    pop;
    logic [3:0] code;

    always_comb begin
        seq_d    = seq_q;
        pop      = 1'b0;
        rd       = (seq_q.st == SEQ_READ) && !fifo_full && !clr;
        seq_d.we = rd;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (!q_empty) begin
                    pop        = 1'b1;
                    seq_d.st   = SEQ_READ;
                    seq_d.addr = q_start;
                    seq_d.left = q_nsl;
                    seq_d.tsl  = q_tsl;
                end
            end
            SEQ_READ: begin
                if (rd) begin
                    seq_d.addr = seq_q.addr + 1'b1;
                    if (seq_q.left == '0) begin
                        if (!q_empty) begin
                            pop        = 1'b1;
                            seq_d.addr = q_start;
                            seq_d.left = q_nsl;
                            seq_d.tsl  = q_tsl;
                        end else begin
                            seq_d.st = SEQ_IDLE;
                        end
                    end else begin
                        seq_d.left = seq_q.left - 1'b1;
                    end
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
        if (clr) begin
            seq_d.st  = SEQ_IDLE;
            seq_d.we  = 1'b0;
            seq_d.tsl = '0;
            pop       = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        if (seq_q.st != SEQ_READ) begin
            code = STAT_IDLE;
        end else if (fifo_full) begin
            code = STAT_STALL;
        end else begin
            code = STAT_READ;
        end
    end

    assign q_pop   = pop;
    assign rd_en   = rd;
    assign rd_addr = seq_q.addr;
    assign fifo_we = seq_q.we && !fifo_full && !clr;
    assign status  = {seq_q.tsl, code};

endmodule

// File: rtl/lbuf_rdctl.sv
`timescale 1ns/1ps
module lbuf_rdctl #(
    parameter int AW     = 9,
    parameter int NSL_W  = 3,
    parameter int TS_W   = 4,
    parameter int BCN_W  = 7,
    parameter int ERR_W  = 4,
    parameter int VLD_W  = 6,
    parameter int DAT_W  = 192,
    parameter int QDEPTH = 4,
    localparam int REC_W = BCN_W + ERR_W + VLD_W + DAT_W,
    localparam int QE_W  = AW + NSL_W + TS_W,
    localparam int ST_W  = TS_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_clr,
    input  logic             sync_in,
    input  logic [BCN_W-1:0] bcn_in,
    input  logic [VLD_W-1:0] vld_in,
    input  logic [DAT_W-1:0] dat_in,
    input  logic [AW-1:0]    lat_preload,
    input  logic             accept_in,
    input  logic [NSL_W-1:0] nslice_in,
    input  logic [TS_W-1:0]  tslice_in,
    input  logic             fifo_full,
    output logic             buf_wr_en,
    output logic [AW-1:0]    buf_wr_addr,
    output logic [REC_W-1:0] buf_wr_data,
    output logic             buf_rd_en,
    output logic [AW-1:0]    buf_rd_addr,
    output logic             fifo_wr_en,
    output logic [ST_W-1:0]  status
);

    logic [AW-1:0]    start_slot;
    logic [QE_W-1:0]  acc_entry;
    logic [QE_W-1:0]  head_entry;
    logic             acc_push;
    logic             head_pop;
    logic             q_empty;

    lbuf_wrside #(
        .AW   (AW),
        .BCN_W(BCN_W),
        .ERR_W(ERR_W),
        .VLD_W(VLD_W),
        .DAT_W(DAT_W)
    ) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_in(sync_in),
        .bcn_in (bcn_in),
        .vld_in (vld_in),
        .dat_in (dat_in),
        .wr_en  (buf_wr_en),
        .wr_addr(buf_wr_addr),
        .wr_data(buf_wr_data)
    );

    assign start_slot = buf_wr_addr - lat_preload;
    assign acc_entry  = {start_slot, nslice_in, tslice_in};
    assign acc_push   = accept_in && !sw_clr;

    lbuf_accq #(
        .EW   (QE_W),
        .DEPTH(QDEPTH)
    ) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_clr),
        .push     (acc_push),
        .push_data(acc_entry),
        .pop      (head_pop),
        .pop_data (head_entry),
        .empty    (q_empty)
    );

    lbuf_rdseq #(
        .AW   (AW),
        .NSL_W(NSL_W),
        .TS_W (TS_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sw_clr),
        .fifo_full(fifo_full),
        .q_empty  (q_empty),
        .q_start  (head_entry[QE_W-1 -: AW]),
        .q_nsl    (head_entry[TS_W +: NSL_W]),
        .q_tsl    (head_entry[TS_W-1:0]),
        .q_pop    (head_pop),
        .rd_en    (buf_rd_en),
        .rd_addr  (buf_rd_addr),
        .fifo_we  (fifo_wr_en),
        .status   (status)
    );

endmodule

// File: rtl/lbuf_rdctl_chk.sv
`timescale 1ns/1ps
module lbuf_rdctl_chk #(
    parameter int AW   = 9,
    parameter int ST_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sw_clr,
    input logic            fifo_full,
    input logic            buf_wr_en,
    input logic [AW-1:0]   buf_wr_addr,
    input logic            buf_rd_en,
    input logic            fifo_wr_en,
    input logic [ST_W-1:0] status
);

    assert_wr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> (buf_wr_addr == AW'($past(buf_wr_addr) + 1'b1)));

    assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_wr_en |=> $stable(buf_wr_addr));

    assert_no_rd_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> !fifo_full);

    assert_we_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> $past(buf_rd_en));

    assert_no_we_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !fifo_full);

    assert_clr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (!buf_rd_en && !fifo_wr_en));

    assert_rd_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> (status[3:0] == 4'd1));

endmodule

bind lbuf_rdctl lbuf_rdctl_chk #(.AW(AW), .ST_W(ST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_clr     (sw_clr),
    .fifo_full  (fifo_full),
    .buf_wr_en  (buf_wr_en),
    .buf_wr_addr(buf_wr_addr),
    .buf_rd_en  (buf_rd_en),
    .fifo_wr_en (fifo_wr_en),
    .status     (status)
);

// File: tb/sim_lbuf_rdctl.sv
`timescale 1ns/1ps
module sim_lbuf_rdctl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_clr = 1'b0;
    logic         sync_in = 1'b0;
    logic [6:0]   bcn_in = '0;
    logic [5:0]   vld_in = '0;
    logic [191:0] dat_in = '0;
    logic [8:0]   lat_preload = 9'd10;
    logic         accept_in = 1'b0;
    logic [2:0]   nslice_in = '0;
    logic [3:0]   tslice_in = '0;
    logic         fifo_full = 1'b0;
    logic         buf_wr_en;
    logic [8:0]   buf_wr_addr;
    logic [208:0] buf_wr_data;
    logic         buf_rd_en;
    logic [8:0]   buf_rd_addr;
    logic         fifo_wr_en;
    logic [7:0]   status;

    int nchk = 0;
    int nerr = 0;
    int bw = 0;
    bit done = 0;

    typedef struct packed {
        logic [8:0]   a;
        logic [208:0] r;
    } exp_t;
    exp_t exp_q[$];

    logic [208:0] ref_mem [512];
    logic [208:0] ram [512];
    logic [208:0] ram_q = '0;
    logic [208:0] hold_rec = '0;
    bit           hold_v = 0;

    always #2.5 clk = ~clk;

    lbuf_rdctl u0 (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .sync_in(sync_in),
        .bcn_in(bcn_in), .vld_in(vld_in), .dat_in(dat_in),
        .lat_preload(lat_preload), .accept_in(accept_in),
        .nslice_in(nslice_in), .tslice_in(tslice_in), .fifo_full(fifo_full),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr),
        .fifo_wr_en(fifo_wr_en), .status(status)
    );

    // behavioural buffer with one-cycle read latency
    always @(posedge clk) begin
        if (buf_wr_en) ram[buf_wr_addr] <= buf_wr_data;
        if (buf_rd_en) ram_q <= ram[buf_rd_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] bcn_of(int k);
        return 7'(k * 5 + 3);
    endfunction
    function automatic logic [5:0] vld_of(int k);
        return 6'(k ^ (k >> 3));
    endfunction
    function automatic logic [191:0] dat_of(int k);
        logic [191:0] v;
        for (int j = 0; j < 6; j++) v[j*32 +: 32] = 32'(k * 32'h01000193 + j * 77);
        return v;
    endfunction

    // driver: called just after a falling edge, returns at the next one
    task automatic cyc(input bit s, input bit a, input logic [2:0] n, input logic [3:0] t,
                       input bit c, input bit f, input bit keep);
        sync_in   = s;
        accept_in = a;
        nslice_in = n;
        tslice_in = t;
        sw_clr    = c;
        fifo_full = f;
        if (s) begin
            bcn_in = bcn_of(bw);
            vld_in = vld_of(bw);
            dat_in = dat_of(bw);
            ref_mem[bw % 512] = {bcn_of(bw), 4'b0000, vld_of(bw), dat_of(bw)};
        end
        if (a && keep && !c) begin
            logic [8:0] st;
            st = 9'(bw) - lat_preload;
            for (int i = 0; i <= int'(n); i++) begin
                logic [8:0] ad;
                ad = st + 9'(i);
                exp_q.push_back('{a: ad, r: ref_mem[ad]});
            end
        end
        @(posedge clk);
        if (s) bw++;
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(0, 0, 3'd0, 4'd0, 0, 0, 0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(buf_wr_en == sync_in, "R1 write enable", 256'(buf_wr_en), 256'(sync_in));
            if (sync_in) begin
                chk(buf_wr_addr == 9'(bw), "R2 write address", 256'(buf_wr_addr), 256'(9'(bw)));
                chk(buf_wr_data == {bcn_in, 4'b0000, vld_in, dat_in}, "R1 record packing",
                    256'(buf_wr_data), 256'({bcn_in, 4'b0000, vld_in, dat_in}));
            end
            if (hold_v) begin
                chk(fifo_wr_en == (!fifo_full && !sw_clr), "R5 fifo write enable",
                    256'(fifo_wr_en), 256'(!fifo_full && !sw_clr));
                if (fifo_wr_en)
                    chk(ram_q == hold_rec, "R5 record to fifo", 256'(ram_q), 256'(hold_rec));
                hold_v = 0;
            end else begin
                chk(!fifo_wr_en, "R5 no write without read", 256'(fifo_wr_en), 256'(0));
            end
            if (buf_rd_en) begin
                chk(!fifo_full, "R6 read while full", 256'(fifo_full), 256'(0));
                if (exp_q.size() == 0) begin
                    chk(0, "R7 unexpected read", 256'(buf_rd_addr), 256'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(buf_rd_addr == e.a, "R3 R4 read address", 256'(buf_rd_addr), 256'(e.a));
                    hold_rec = e.r;
                    hold_v = 1;
                end
            end
            if (sw_clr) exp_q.delete();
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1;
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            ref_mem[i] = '0;
            ram[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk(status == 8'h00, "R10 status after reset", 256'(status), 256'(0));
        chk(!buf_rd_en && !fifo_wr_en, "R10 quiet after reset",
            256'({buf_rd_en, fifo_wr_en}), 256'(0));
        chk(buf_wr_addr == 9'd0, "R2 pointer after reset", 256'(buf_wr_addr), 256'(0));
        @(negedge clk);

        // fill, then a single burst; R3 start slot and R9 status
        for (int i = 0; i < 20; i++) cyc(1, 0, 3'd0, 4'd0, 0, 0, 0);
        lat_preload = 9'd10;
        cyc(0, 1, 3'd3, 4'hA, 0, 0, 1);
        cyc(0, 0, 3'd0, 4'd0, 0, 0, 0);
        chk(status == 8'hA1, "R9 status reading", 256'(status), 256'(8'hA1));
        chk(buf_rd_en && buf_rd_addr == 9'd10, "R3 first read two cycles after accept",
            256'({buf_rd_en, buf_rd_addr}), 256'({1'b1, 9'd10}));
        idle(10);
        chk(status[3:0] == 4'd0, "R9 idle code", 256'(status[3:0]), 256'(0));

        // R7 queued accepts with writes running
        for (int i = 0; i < 30; i++) begin
            if (i == 2)       cyc(1, 1, 3'd7, 4'h3, 0, 0, 1);
            else if (i == 4)  cyc(1, 1, 3'd0, 4'h4, 0, 0, 1);
            else if (i == 5)  cyc(1, 1, 3'd2, 4'h5, 0, 0, 1);
            else              cyc(1, 0, 3'd0, 4'd0, 0, 0, 0);
        end
        idle(10);
        chk(exp_q.size() == 0, "R7 queued bursts served", 256'(exp_q.size()), 256'(0));

        // R6 stall on full mid-burst
        cyc(0, 1, 3'd7, 4'h5, 0, 0, 1);
        cyc(0, 0, 3'd0, 4'd0, 0, 0, 0);
        cyc(0, 0, 3'd0, 4'd0, 0, 0, 0);
        fifo_full = 1'b1;
        #1;
        chk(status == 8'h52, "R9 stall code", 256'(status), 256'(8'h52));
        chk(!buf_rd_en, "R6 no read when full", 256'(buf_rd_en), 256'(0));
        for (int i = 0; i < 4; i++) cyc(0, 0, 3'd0, 4'd0, 0, 1, 0);
        idle(12);
        chk(exp_q.size() == 0, "R6 burst resumed", 256'(exp_q.size()), 256'(0));

        // R7 overflow: six accepts in a row, QDEPTH+1 kept
        for (int i = 0; i < 6; i++) cyc(0, 1, 3'd7, 4'(i), 0, 0, (i < 5));
        idle(60);
        chk(exp_q.size() == 0, "R7 overflow accepts served", 256'(exp_q.size()), 256'(0));

        // R4 start slot below zero wraps through 511 to 0
        lat_preload = 9'(bw + 3);
        cyc(0, 1, 3'd7, 4'h6, 0, 0, 1);
        idle(12);
        chk(exp_q.size() == 0, "R4 wrap burst", 256'(exp_q.size()), 256'(0));

        // R2 write pointer once around the buffer, then read behind it
        for (int i = 0; i < 520; i++) cyc(1, 0, 3'd0, 4'd0, 0, 0, 0);
        lat_preload = 9'd12;
        cyc(0, 1, 3'd5, 4'h7, 0, 0, 1);
        idle(10);
        chk(exp_q.size() == 0, "R2 burst after pointer wrap", 256'(exp_q.size()), 256'(0));

        // R8 clear mid-burst with waiting accepts, sync and accept alongside
        cyc(0, 1, 3'd7, 4'h9, 0, 0, 1);
        cyc(0, 1, 3'd7, 4'h9, 0, 0, 1);
        cyc(0, 1, 3'd7, 4'h9, 0, 0, 1);
        cyc(0, 0, 3'd0, 4'd0, 0, 0, 0);
        cyc(1, 1, 3'd7, 4'h9, 1, 0, 0);
        chk(!buf_rd_en, "R8 no read after clear", 256'(buf_rd_en), 256'(0));
        idle(20);
        chk(status == 8'h00, "R8 status cleared", 256'(status), 256'(0));
        chk(exp_q.size() == 0, "R8 nothing left", 256'(exp_q.size()), 256'(0));
        cyc(0, 1, 3'd1, 4'h2, 0, 0, 1);
        idle(6);
        chk(exp_q.size() == 0, "R8 accept after clear", 256'(exp_q.size()), 256'(0));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule